// File: doc/BRIEF.md
# Synchronous Frame Receive Address Filter

This block is the receive front end of one channel running in synchronous, frame-oriented mode. Frames reach it already de-flagged and de-stuffed as a stream of bytes, with a valid strobe and a marker on the final byte. When the receiver is hunting and its byte store is empty, the first byte of each frame is compared with the programmed station address and with the all-ones broadcast address. A match accepts the frame and ends the hunt. Any other frame is thrown away in full, and the receiver keeps hunting.

An accepted frame is written into a byte store. The block then appends two fixed check-field bytes and a trailing zero byte. The host can read the frame only after these three bytes are in place. The host drains the store one byte per read strobe. Two status bytes report whether data is available, whether the receiver is hunting, the near-end-of-frame abort indication and the end-of-frame flag. Three one-cycle event pulses indicate sync/hunt completion, receive-character service and break/abort. The host's interrupt logic collects these pulses.

Top module: `sdlc_rx_filter`

## Requirements
- R1: After reset the receiver is not hunting and the store is empty. rr0 reads 0x80, rr1 reads 0x07 and no event pulse is high.
- R2: A one-cycle pulse on hunt_cmd sets the hunt flag, which rr0 bit 4 shows from the next cycle.
- R3: While hunting with an empty store, a frame is accepted when its first byte is 0xFF or equals stn_addr, and acceptance clears the hunt flag. A frame that does not match is dropped in full, and hunting continues. A frame that starts while the receiver is not hunting is also dropped.
- R4: An accepted frame's bytes are returned in arrival order, followed by 0xA5, 0xA5 and 0x00. No byte is readable until the 0x00 has been stored. rd_data shows the head byte while one is available.
- R5: ev_sync is high for one cycle, in the cycle after acceptance, when sync_evt_en is 1.
- R6: rx_int_mode encodes 0 = off, 1 = first character, 2 = every character, 3 = special only. ev_rxchar pulses in the cycle after acceptance when the mode is 1 or 2. It also pulses in the cycle after any read that leaves bytes in the store, when the mode is 2.
- R7: rr1 bits 3:0 read 0111 and bits 6:4 read 0. rr1 bit 7 is 1 exactly when one readable byte remains.
- R8: rr0 bit 0 is 1 when a readable byte exists. rr0 bit 7 is 1 when two or fewer readable bytes remain, which includes zero. All other rr0 bits are 0 except bit 4, the hunt flag.
- R9: A read that leaves exactly one byte sets the hunt flag. In the next cycle it raises ev_abort if abort_evt_en is 1.
- R10: A read strobe with no readable byte returns 0 on rd_data and changes no state.
- R11: A frame that starts while any byte of the previous frame is still unread is dropped in full, even if the receiver is hunting.
- R12: Payload bytes beyond DEPTH-3 are discarded, so a stored frame never exceeds DEPTH bytes including the three appended bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hunt_cmd | input | 1 | Pulse: enter hunt mode |
| stn_addr | input | 8 | Station address |
| rx_int_mode | input | 2 | Receive event mode (0 off, 1 first char, 2 every char, 3 special only) |
| sync_evt_en | input | 1 | Enable sync/hunt event |
| abort_evt_en | input | 1 | Enable break/abort event |
| in_valid | input | 1 | Incoming byte strobe |
| in_byte | input | 8 | Incoming byte |
| in_last | input | 1 | Marks the final byte of a frame |
| rd_en | input | 1 | Read strobe for the byte store |
| rd_data | output | 8 | Head byte, or 0 when none is readable |
| rr0 | output | 8 | Status: bit0 available, bit4 hunting, bit7 abort |
| rr1 | output | 8 | Frame status: bit7 end of frame, bits 3:0 = 0111 |
| ev_sync | output | 1 | Sync/hunt event pulse |
| ev_rxchar | output | 1 | Receive-character event pulse |
| ev_abort | output | 1 | Break/abort event pulse |

## Verification
Two things can happen in the same cycle: a host read of the second-to-last or the last byte of a frame, and the first byte of a new frame. The read that leaves one byte turns hunting back on at that clock edge. The frame decision uses the state from before that edge, so the new frame still sees the receiver as not hunting. The read of the last byte empties the store at that edge, but the arriving frame still sees the store as non-empty. The bench creates both collisions on purpose. A cycle-by-cycle reference model requires both frames to be dropped. Afterwards an explicit check requires rr0 to read 0x90, and a later broadcast frame must be accepted normally.

// File: rtl/sdlc_rxf_pkg.sv
package sdlc_rxf_pkg;

    localparam logic [7:0] BCAST_ADDR = 8'hFF;
    localparam logic [7:0] CRC_FILL   = 8'hA5;
    localparam logic [7:0] TRAIL_BYTE = 8'h00;
    localparam int         PAD_LEN    = 3;

    typedef enum logic [1:0] {
        RXI_OFF     = 2'd0,
        RXI_FIRST   = 2'd1,
        RXI_ALL     = 2'd2,
        RXI_SPECIAL = 2'd3
    } rxi_mode_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_TAKE,
        FS_SKIP,
        FS_PAD
    } fstate_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } wbeat_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [7:0] stn);
        return (b == BCAST_ADDR) || (b == stn);
    endfunction

    function automatic logic [7:0] pad_byte(input logic [1:0] idx);
        return (idx == 2'd2) ? TRAIL_BYTE : CRC_FILL;
    endfunction

    function automatic logic rxchar_on_accept(input rxi_mode_e m);
        return (m == RXI_FIRST) || (m == RXI_ALL);
    endfunction

endpackage

// File: rtl/rxf_fifo.sv
module rxf_fifo
    import sdlc_rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  wbeat_t        wr,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr.valid) mem[wptr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr.valid) wptr <= bump(wptr);
            if (pop)      rptr <= bump(rptr);
            case ({wr.valid, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/rxf_frame_ctl.sv
module rxf_frame_ctl
    import sdlc_rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          in_last,
    input  logic [7:0]    stn_addr,
    input  logic          hunting,
    input  logic [CW-1:0] count,
    output wbeat_t        wr,
    output logic          accept,
    output logic          frame_done
);
    localparam int PAYLOAD_MAX = DEPTH - PAD_LEN;

    fstate_e    st, st_d;
    logic [1:0] pad_idx, pad_d;
    logic       room, store_empty;

    assign room        = count < CW'(PAYLOAD_MAX);
    assign store_empty = (count == '0);

    always_comb begin
        st_d       = st;
        pad_d      = pad_idx;
        wr         = '0;
        accept     = 1'b0;
        frame_done = 1'b0;
        case (st)
            FS_IDLE: begin
                if (in_valid) begin
                    if (hunting && store_empty && addr_hit(in_byte, stn_addr)) begin
                        accept  = 1'b1;
                        wr      = '{valid: 1'b1, data: in_byte};
                        st_d    = in_last ? FS_PAD : FS_TAKE;
                        pad_d   = '0;
                    end else begin
                        st_d    = in_last ? FS_IDLE : FS_SKIP;
                    end
                end
            end
            FS_TAKE: begin
                if (in_valid) begin
                    wr = '{valid: room, data: in_byte};
                    if (in_last) begin
                        st_d  = FS_PAD;
                        pad_d = '0;
                    end
                end
            end
            FS_SKIP: begin
                if (in_valid && in_last) st_d = FS_IDLE;
            end
            FS_PAD: begin
                wr = '{valid: 1'b1, data: pad_byte(pad_idx)};
                if (pad_idx == 2'(PAD_LEN - 1)) begin
                    st_d       = FS_IDLE;
                    pad_d      = '0;
                    frame_done = 1'b1;
                end else begin
                    pad_d = pad_idx + 2'd1;
                end
            end
            default: st_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_IDLE;
            pad_idx <= '0;
        end else begin
            st      <= st_d;
            pad_idx <= pad_d;
        end
    end

endmodule

// File: rtl/sdlc_rx_filter.sv
module sdlc_rx_filter
    import sdlc_rxf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hunt_cmd,
    input  logic [7:0] stn_addr,
    input  logic [1:0] rx_int_mode,
    input  logic       sync_evt_en,
    input  logic       abort_evt_en,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [7:0] rr0,
    output logic [7:0] rr1,
    output logic       ev_sync,
    output logic       ev_rxchar,
    output logic       ev_abort
);
    localparam int CW = $clog2(DEPTH + 1);

    rxi_mode_e     mode;
    wbeat_t        wr;
    logic          accept, frame_done;
    logic [CW-1:0] count, left, remain;
    logic [7:0]    head;
    logic          hunting, resident, avail, pop, rehunt;

    assign mode   = rxi_mode_e'(rx_int_mode);
    assign avail  = resident && (count != '0);
    assign pop    = rd_en && avail;
    assign left   = count - CW'(1);
    assign rehunt = pop && (left == CW'(1));
    assign remain = resident ? count : '0;

    rxf_frame_ctl #(.DEPTH(DEPTH), .CW(CW)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_last    (in_last),
        .stn_addr   (stn_addr),
        .hunting    (hunting),
        .count      (count),
        .wr         (wr),
        .accept     (accept),
        .frame_done (frame_done)
    );

    rxf_fifo #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .pop   (pop),
        .head  (head),
        .count (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hunting   <= 1'b0;
            resident  <= 1'b0;
            ev_sync   <= 1'b0;
            ev_rxchar <= 1'b0;
            ev_abort  <= 1'b0;
        end else begin
            if (hunt_cmd || rehunt) hunting <= 1'b1;
            else if (accept)        hunting <= 1'b0;

            if (frame_done)                     resident <= 1'b1;
            else if (pop && (left == '0))       resident <= 1'b0;

            ev_sync   <= accept && sync_evt_en;
            ev_rxchar <= (accept && rxchar_on_accept(mode))
                       || (pop && (left != '0) && (mode == RXI_ALL));
            ev_abort  <= rehunt && abort_evt_en;
        end
    end

    assign rd_data = avail ? head : 8'h00;
    assign rr0     = {(remain <= CW'(2)), 2'b00, hunting, 3'b000, avail};
    assign rr1     = {(remain == CW'(1)), 3'b000, 4'b0111};

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic       clk,
    input logic       rst,
    input logic       hunt_cmd,
    input logic [1:0] rx_int_mode,
    input logic       sync_evt_en,
    input logic       abort_evt_en,
    input logic [7:0] rd_data,
    input logic [7:0] rr0,
    input logic [7:0] rr1,
    input logic       ev_sync,
    input logic       ev_rxchar,
    input logic       ev_abort
);
    AST_SYNC_ENABLED: assert property (@(posedge clk) disable iff (rst)
        ev_sync |-> $past(sync_evt_en)); // R5

    AST_ACCEPT_ENDS_HUNT: assert property (@(posedge clk) disable iff (rst)
        (ev_sync && !$past(hunt_cmd)) |-> !rr0[4]); // R3

    AST_RXCHAR_MODE: assert property (@(posedge clk) disable iff (rst)
        ev_rxchar |-> ($past(rx_int_mode) == 2'd1 || $past(rx_int_mode) == 2'd2)); // R6

    AST_ABORT_REHUNTS: assert property (@(posedge clk) disable iff (rst)
        ev_abort |-> (rr0[4] && $past(abort_evt_en) && rr1[7])); // R9

    AST_EOF_ONE_LEFT: assert property (@(posedge clk) disable iff (rst)
        rr1[7] |-> (rr0[0] && rr0[7])); // R7

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rr0[0] |-> (rd_data == 8'h00)); // R10

endmodule

bind sdlc_rx_filter rxf_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .hunt_cmd     (hunt_cmd),
    .rx_int_mode  (rx_int_mode),
    .sync_evt_en  (sync_evt_en),
    .abort_evt_en (abort_evt_en),
    .rd_data      (rd_data),
    .rr0          (rr0),
    .rr1          (rr1),
    .ev_sync      (ev_sync),
    .ev_rxchar    (ev_rxchar),
    .ev_abort     (ev_abort)
);

// File: tb/sim_sdlc_rx_filter.sv
`timescale 1ns/1ps
module sim_sdlc_rx_filter;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hunt_cmd = 0, sync_evt_en = 1, abort_evt_en = 1;
    logic [7:0] stn_addr = 8'h3C;
    logic [1:0] rx_int_mode = 2'd1;
    logic       in_valid = 0, in_last = 0, rd_en = 0;
    logic [7:0] in_byte = 0;
    logic [7:0] rd_data, rr0, rr1;
    logic       ev_sync, ev_rxchar, ev_abort;

    always #10 clk = ~clk;

    sdlc_rx_filter #(.DEPTH(DEPTH)) u0 (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [7:0] m_q[$];
    bit m_hunt = 0, m_done = 0, m_es = 0, m_er = 0, m_ea = 0;
    int m_st = 0, m_pad = 0;

    task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit h = m_hunt;
        bit emp = (m_q.size() == 0);
        bit av = m_done && !emp;
        bit hset = 0, acc = 0;
        m_es = 0; m_er = 0; m_ea = 0;
        if (rd_en && av) begin
            void'(m_q.pop_front());
            if (m_q.size() != 0 && rx_int_mode == 2'd2) m_er = 1;
            if (m_q.size() == 1) begin hset = 1; m_ea = abort_evt_en; end
            if (m_q.size() == 0) m_done = 0;
        end
        case (m_st)
            0: if (in_valid) begin
                if (h && emp && (in_byte == 8'hFF || in_byte == stn_addr)) begin
                    acc = 1;
                    m_q.push_back(in_byte);
                    m_es = sync_evt_en;
                    if (rx_int_mode == 2'd1 || rx_int_mode == 2'd2) m_er = 1;
                    m_st = in_last ? 3 : 1;
                    m_pad = 0;
                end else m_st = in_last ? 0 : 2;
            end
            1: if (in_valid) begin
                if (m_q.size() < DEPTH - 3) m_q.push_back(in_byte);
                if (in_last) begin m_st = 3; m_pad = 0; end
            end
            2: if (in_valid && in_last) m_st = 0;
            default: begin
                m_q.push_back(m_pad == 2 ? 8'h00 : 8'hA5);
                m_pad++;
                if (m_pad == 3) begin m_st = 0; m_done = 1; end
            end
        endcase
        if (hunt_cmd || hset) m_hunt = 1;
        else if (acc) m_hunt = 0;
    endtask

    function automatic int m_rem();
        return m_done ? m_q.size() : 0;
    endfunction

    task automatic compare_all();
        int r = m_rem();
        chk8(rd_data, r != 0 ? m_q[0] : 8'h00, "R4 rd_data");
        chk8({rr0[7], rr0[6:5], rr0[3:0]}, {7'(r <= 2), 6'(r != 0)} , "R8 rr0");
        chk8({7'b0, rr0[4]}, {7'b0, m_hunt}, "R3 rr0 hunt bit");
        chk8(rr1, {(r == 1), 7'h07}, "R7 rr1");
        chk8({7'b0, ev_sync}, {7'b0, m_es}, "R5 ev_sync");
        chk8({7'b0, ev_rxchar}, {7'b0, m_er}, "R6 ev_rxchar");
        chk8({7'b0, ev_abort}, {7'b0, m_ea}, "R9 ev_abort");
    endtask

    task automatic cyc(input bit iv, input logic [7:0] ib, input bit il, input bit re, input bit hc);
        in_valid = iv; in_byte = ib; in_last = il; rd_en = re; hunt_cmd = hc;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic send(input logic [7:0] fr[$]);
        foreach (fr[i]) cyc(1, fr[i], i == fr.size() - 1, 0, 0);
        repeat (4) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic drain(output int n);
        n = 0;
        while (m_rem() != 0) begin cyc(0, 0, 0, 1, 0); n++; end
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] big[$];
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk8(rr0, 8'h80, "R1 rr0 after reset");
        chk8(rr1, 8'h07, "R1 rr1 after reset");
        chk8({5'b0, ev_sync, ev_rxchar, ev_abort}, 8'h00, "R1 events after reset");

        // R3: frame while not hunting is dropped
        send('{8'h3C, 8'h11, 8'h22});
        chk8(rr0, 8'h80, "R3 frame dropped when not hunting");

        // R2: hunt command
        cyc(0, 0, 0, 0, 1);
        chk8(rr0, 8'h90, "R2 hunt flag set");

        // R10: empty read
        cyc(0, 0, 0, 1, 0);
        chk8(rd_data, 8'h00, "R10 empty read data");
        chk8(rr0, 8'h90, "R10 empty read no state change");

        // R3: non-matching frame dropped, still hunting
        send('{8'h55, 8'h01});
        chk8(rr0, 8'h90, "R3 mismatch keeps hunting");

        // R3/R4/R5/R6: station frame, first-char mode
        send('{8'h3C, 8'hDE, 8'hAD});
        chk8(rr0, 8'h01, "R4 frame resident, hunt cleared");
        drain(n);
        chk8(8'(n), 8'd6, "R4 byte count with pad");
        chk8(rr0, 8'h90, "R9 hunting after drain");

        // R6: every-char mode, broadcast frame, no abort event
        rx_int_mode = 2'd2; abort_evt_en = 0;
        send('{8'hFF, 8'h10, 8'h20, 8'h30});
        drain(n);
        chk8(8'(n), 8'd7, "R6 broadcast frame length");

        // R11 collisions: read to one byte / last byte while frames start
        rx_int_mode = 2'd3; abort_evt_en = 1; sync_evt_en = 0;
        send('{8'hFF, 8'h77});
        repeat (3) cyc(0, 0, 0, 1, 0);
        cyc(1, 8'hFF, 0, 1, 0);
        cyc(1, 8'h01, 1, 0, 0);
        cyc(1, 8'hFF, 1, 1, 0);
        repeat (4) cyc(0, 0, 0, 0, 0);
        chk8(rr0, 8'h90, "R11 colliding frames dropped");
        send('{8'hFF});
        chk8(rr0, 8'h01, "R11 later frame accepted");
        drain(n);
        chk8(8'(n), 8'd4, "R3 single-byte frame length");

        // R12: oversize frame truncated
        rx_int_mode = 2'd0;
        big.push_back(8'h3C);
        for (int i = 1; i < 70; i++) big.push_back(8'(i));
        send(big);
        drain(n);
        chk8(8'(n), 8'(DEPTH), "R12 truncated frame length");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule